// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge Select

This block collects interrupt requests for a small 8-bit processor core and turns them into one vectored service request at a time. There are three sources. The first is an external pin. It is synchronised and passed through an edge detector, and a two-bit mode field selects the edge: none, rising, falling or both. The second and third are a timer overflow pulse and a time-base overflow pulse. Each source has a sticky request flag and its own enable bit, and one global enable gates all of them.

When the global enable is set, at least one enabled flag is pending and the core reports that its return stack has room, the controller latches the winning source. The external source beats the timer, and the timer beats the time base. In the next cycle the controller raises a one-cycle take strobe with the vector address. When the core acknowledges, the controller clears the served flag and the global enable, so nested service cannot start until software turns the global enable back on. Software can also clear any flag by writing a one to it.

Top module: `vic_edge_ctrl`

## Requirements
- R1: The external flag is set only by a pin edge that matches the mode in control bits [7:6]: 00 none, 01 low-to-high, 10 high-to-low, 11 either direction. The control register reads back the whole written byte.
- R2: A pin change driven before clock edge k sets the external flag at edge k+2 and not earlier. A one-cycle timer or time-base overflow pulse sets its flag at the next edge.
- R3: Flags are sticky. They stay set while the global enable is off. Flag bits are bit0 external, bit1 timer and bit2 time base.
- R4: A source is taken only if the global enable (enable word bit0), its own enable (bit1 external, bit2 timer, bit3 time base) and its flag are all set and the stack-full input is low. The take strobe rises one cycle after the edge at which these conditions hold.
- R5: The external source takes priority over the timer, and the timer takes priority over the time base.
- R6: The take strobe lasts exactly one cycle. The vector is 0x04 for external, 0x08 for timer and 0x0C for time base.
- R7: An acknowledge that arrives during or after the take cycle clears the served flag and the global enable. An acknowledge with no request outstanding has no effect.
- R8: A write-one to a flag-clear bit clears that flag, except that an overflow or edge arriving in the same cycle keeps the flag set.
- R9: After reset the flags, the enables, the control byte and the take strobe are all zero.
- R10: Once a request has been offered, no further take is issued until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| tb_ovf_i | input | 1 | Time-base overflow pulse |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control byte; bits [7:6] select the edge mode |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 4 | Bit0 global, bit1 external, bit2 timer, bit3 time base |
| flag_clr_i | input | 3 | Write-one-to-clear flag bits |
| stack_full_i | input | 1 | Core return stack is full |
| irq_ack_i | input | 1 | Core acknowledges the offered vector |
| irq_take_o | output | 1 | One-cycle service request |
| irq_vec_o | output | 8 | Vector address of the offered source |
| flags_o | output | 3 | Request flags |
| gie_o | output | 1 | Global enable |
| ctrl_o | output | 8 | Control register readback |

## Verification
Random edge modes and random pin moves are checked against a bench function for edge matching, so a detector that swapped the rising and falling codes, or that still fired in mode 00, is caught. Random mixes of pending flags and enables check the winner and its vector: a wrong priority order would offer the timer while the external flag is pending. Directed cases cover a full stack, which a faulty design would ignore by taking at once; a held-off acknowledge, where a faulty design would strobe take again; a stray acknowledge, which must not clear anything; and a clear arriving in the same cycle as a new overflow, which must not lose the new event.

// File: rtl/vic_pkg.sv
// Shared constants and types for the vectored interrupt controller.
// Assumes source index order equals priority order (index 0 highest).
package vic_pkg;
    localparam int NSRC    = 3;
    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_TB  = 2;
    localparam int VEC_W   = 8;
    localparam int CTRL_W  = 8;
    localparam int EDGE_LO = 6;
    localparam int EN_W    = NSRC + 1;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_t;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'b00,
        ARB_OFFER = 2'b01,
        ARB_HOLD  = 2'b10
    } arb_state_t;
endpackage

// File: rtl/vic_edge_detect.sv
// Synchronises an asynchronous pin and emits a one-cycle pulse on the
// edge kinds selected by mode_i. Assumes the pin is low at reset release.
module vic_edge_detect
    import vic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  edge_mode_t mode_i,
    output logic       edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;
    logic                   rise;
    logic                   fall;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            // Single capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_chain
            // Shift the pin through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];

    // Remember the previous synchronised sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Classify the transition and gate it by the selected mode
    always_comb begin
        rise   = level & ~prev_q;
        fall   = ~level & prev_q;
        edge_o = (mode_i[0] & rise) | (mode_i[1] & fall);
    end
endmodule

// File: rtl/vic_flag_bank.sv
// Sticky request flags, one per source. A set in the same cycle as
// any clear wins, so no event is lost.
module vic_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] svc_clr_i,
    input  logic [N-1:0] sw_clr_i,
    output logic [N-1:0] flags_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            // Per-source flag: set wins over service or software clear
            always_ff @(posedge clk) begin
                if (!rst_n)                         flags_o[g] <= 1'b0;
                else if (set_i[g])                  flags_o[g] <= 1'b1;
                else if (svc_clr_i[g] | sw_clr_i[g]) flags_o[g] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/vic_arbiter.sv
// Picks the highest-priority pending and enabled source (lowest index),
// latches it, offers it for one cycle and waits for the acknowledge.
// Assumes acknowledge is only meaningful while an offer is outstanding.
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int N        = 3,
    parameter int VW       = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  flags_i,
    input  logic [N-1:0]  en_i,
    input  logic          gie_i,
    input  logic          stack_full_i,
    input  logic          ack_i,
    output logic          take_o,
    output logic [VW-1:0] vec_o,
    output logic [N-1:0]  svc_o,
    output logic          gie_clr_o
);
    arb_state_t    state_q;
    logic [N-1:0]  pending;
    logic [N-1:0]  win_oh;
    logic [VW-1:0] win_vec;
    logic [N-1:0]  sel_q;
    logic          grant;
    logic          done;

    // Fixed-priority pick: scan from lowest priority so index 0 wins last
    always_comb begin
        pending = flags_i & en_i;
        win_oh  = '0;
        win_vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                win_oh    = '0;
                win_oh[i] = 1'b1;
                win_vec   = VW'(VEC_BASE + VEC_STEP * i);
            end
        end
    end

    assign grant = (state_q == ARB_IDLE) && gie_i && (|pending) && !stack_full_i;
    assign done  = (state_q != ARB_IDLE) && ack_i;

    // Offer state machine with latched winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            sel_q   <= '0;
            vec_o   <= '0;
        end else begin
            case (state_q)
                ARB_IDLE: if (grant) begin
                    state_q <= ARB_OFFER;
                    sel_q   <= win_oh;
                    vec_o   <= win_vec;
                end
                ARB_OFFER: state_q <= ack_i ? ARB_IDLE : ARB_HOLD;
                ARB_HOLD:  if (ack_i) state_q <= ARB_IDLE;
                default:   state_q <= ARB_IDLE;
            endcase
        end
    end

    // Service side effects on acknowledge
    always_comb begin
        take_o    = (state_q == ARB_OFFER);
        svc_o     = done ? sel_q : '0;
        gie_clr_o = done;
    end
endmodule

// File: rtl/vic_edge_ctrl.sv
// Top of the vectored interrupt controller: control and enable
// registers, edge detector, flag bank and arbiter.
// Assumes one-cycle overflow pulses from the counters.
module vic_edge_ctrl
    import vic_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VEC_BASE    = 4,
    parameter int VEC_STEP    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin_i,
    input  logic              tmr_ovf_i,
    input  logic              tb_ovf_i,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              en_wr_i,
    input  logic [EN_W-1:0]   en_wdata_i,
    input  logic [NSRC-1:0]   flag_clr_i,
    input  logic              stack_full_i,
    input  logic              irq_ack_i,
    output logic              irq_take_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    output logic [NSRC-1:0]   flags_o,
    output logic              gie_o,
    output logic [CTRL_W-1:0] ctrl_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              gie_q;
    logic [NSRC-1:0]   src_en_q;
    logic              ext_edge;
    logic [NSRC-1:0]   set_vec;
    logic [NSRC-1:0]   svc_clr;
    logic              gie_clr;
    edge_mode_t        mode;

    // Control register holding the edge mode field
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (ctrl_wr_i) ctrl_q <= ctrl_wdata_i;
    end

    // Global enable: service clear beats a software write
    always_ff @(posedge clk) begin
        if (!rst_n)       gie_q <= 1'b0;
        else if (gie_clr) gie_q <= 1'b0;
        else if (en_wr_i) gie_q <= en_wdata_i[0];
    end

    // Per-source enables
    always_ff @(posedge clk) begin
        if (!rst_n)       src_en_q <= '0;
        else if (en_wr_i) src_en_q <= en_wdata_i[EN_W-1:1];
    end

    assign mode = edge_mode_t'(ctrl_q[EDGE_LO+1:EDGE_LO]);

    vic_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .mode_i (mode),
        .edge_o (ext_edge)
    );

    // Gather the set events in source order
    always_comb begin
        set_vec          = '0;
        set_vec[SRC_EXT] = ext_edge;
        set_vec[SRC_TMR] = tmr_ovf_i;
        set_vec[SRC_TB]  = tb_ovf_i;
    end

    vic_flag_bank #(.N(NSRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .svc_clr_i (svc_clr),
        .sw_clr_i  (flag_clr_i),
        .flags_o   (flags_o)
    );

    vic_arbiter #(
        .N        (NSRC),
        .VW       (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .flags_i      (flags_o),
        .en_i         (src_en_q),
        .gie_i        (gie_q),
        .stack_full_i (stack_full_i),
        .ack_i        (irq_ack_i),
        .take_o       (irq_take_o),
        .vec_o        (irq_vec_o),
        .svc_o        (svc_clr),
        .gie_clr_o    (gie_clr)
    );

    assign gie_o  = gie_q;
    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/vic_edge_ctrl_chk.sv
// Property checker for vic_edge_ctrl, attached by bind.
module vic_edge_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       take,
    input logic [7:0] vec,
    input logic       gie,
    input logic [2:0] flags,
    input logic [2:0] src_en,
    input logic       stack_full,
    input logic       ack,
    input logic [1:0] edge_sel
);
    a_r6_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
    a_r6_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (vec == 8'h04 || vec == 8'h08 || vec == 8'h0C));
    a_r4_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take) |-> ($past(gie) && !$past(stack_full)));
    a_r7_ack_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ack) |=> !gie);
    a_r5_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec != 8'h04) |-> !($past(flags[0]) && $past(src_en[0])));
    a_r1_off_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> ($past(edge_sel) != 2'b00));
    a_r10_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> $stable(vec));
endmodule

bind vic_edge_ctrl vic_edge_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (irq_take_o),
    .vec        (irq_vec_o),
    .gie        (gie_o),
    .flags      (flags_o),
    .src_en     (src_en_q),
    .stack_full (stack_full_i),
    .ack        (irq_ack_i),
    .edge_sel   (ctrl_o[7:6])
);

// File: tb/vic_edge_ctrl_tb.sv
module vic_edge_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin_i = 1'b0;
    logic       tmr_ovf_i = 1'b0;
    logic       tb_ovf_i = 1'b0;
    logic       ctrl_wr_i = 1'b0;
    logic [7:0] ctrl_wdata_i = '0;
    logic       en_wr_i = 1'b0;
    logic [3:0] en_wdata_i = '0;
    logic [2:0] flag_clr_i = '0;
    logic       stack_full_i = 1'b0;
    logic       irq_ack_i = 1'b0;
    logic       irq_take_o;
    logic [7:0] irq_vec_o;
    logic [2:0] flags_o;
    logic       gie_o;
    logic [7:0] ctrl_o;

    int nchecks = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    vic_edge_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i),
        .tmr_ovf_i(tmr_ovf_i), .tb_ovf_i(tb_ovf_i),
        .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
        .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
        .flag_clr_i(flag_clr_i), .stack_full_i(stack_full_i),
        .irq_ack_i(irq_ack_i), .irq_take_o(irq_take_o),
        .irq_vec_o(irq_vec_o), .flags_o(flags_o),
        .gie_o(gie_o), .ctrl_o(ctrl_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        ctrl_wr_i = 1'b1; ctrl_wdata_i = v; tick(); ctrl_wr_i = 1'b0;
    endtask

    task automatic write_en(input logic [3:0] v);
        en_wr_i = 1'b1; en_wdata_i = v; tick(); en_wr_i = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] v);
        flag_clr_i = v; tick(); flag_clr_i = '0;
    endtask

    task automatic pulse_tmr();
        tmr_ovf_i = 1'b1; tick(); tmr_ovf_i = 1'b0;
    endtask

    task automatic pulse_tb();
        tb_ovf_i = 1'b1; tick(); tb_ovf_i = 1'b0;
    endtask

    task automatic raise_ext();
        write_ctrl(8'h40);
        ext_pin_i = 1'b1; repeat (4) tick();
        ext_pin_i = 1'b0; repeat (4) tick();
    endtask

    function automatic logic exp_edge(input logic [1:0] m, input logic o, input logic n);
        return (m[0] && !o && n) || (m[1] && o && !n);
    endfunction

    function automatic logic [7:0] exp_vec(input logic [2:0] p);
        if (p[0]) return 8'h04;
        if (p[1]) return 8'h08;
        return 8'h0C;
    endfunction

    function automatic logic [2:0] exp_win(input logic [2:0] p);
        if (p[0]) return 3'b001;
        if (p[1]) return 3'b010;
        return 3'b100;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R9 reset state
        chk("R9 flags", 32'(flags_o), 0);
        chk("R9 gie", 32'(gie_o), 0);
        chk("R9 take", 32'(irq_take_o), 0);
        chk("R9 ctrl", 32'(ctrl_o), 0);

        // R2 synchroniser latency for a rising edge
        write_ctrl(8'h40);
        ext_pin_i = 1'b1;
        tick(); tick();
        chk("R2 not yet at k+1", 32'(flags_o[0]), 0);
        tick();
        chk("R2 set at k+2", 32'(flags_o[0]), 1);
        clear_flags(3'b001);
        chk("R8 sw clear", 32'(flags_o[0]), 0);

        // R2 overflow pulses set flags next edge
        pulse_tmr();
        chk("R2 timer flag", 32'(flags_o), 3'b010);
        pulse_tb();
        chk("R2 time-base flag", 32'(flags_o), 3'b110);
        clear_flags(3'b110);

        // R1 random edge modes
        for (int it = 0; it < 40; it++) begin
            logic [1:0] m;
            logic       o;
            logic       n;
            logic [7:0] cb;
            m  = 2'($urandom % 4);
            cb = {m, 6'($urandom)};
            write_ctrl(cb);
            chk("R1 ctrl readback", 32'(ctrl_o), 32'(cb));
            clear_flags(3'b001);
            o = ext_pin_i;
            n = 1'($urandom % 2);
            ext_pin_i = n;
            repeat (4) tick();
            chk("R1 edge match", 32'(flags_o[0]), 32'(exp_edge(m, o, n)));
        end
        write_ctrl(8'h00);
        ext_pin_i = 1'b0;
        repeat (4) tick();
        chk("R1 mode 00 ignores fall", 32'(flags_o[0]), 0);
        clear_flags(3'b111);

        // R3 sticky while masked, R7 stray ack ignored
        pulse_tmr();
        write_en(4'b0100);
        repeat (3) tick();
        chk("R3 held while masked", 32'(flags_o[1]), 1);
        chk("R3 no take masked", 32'(irq_take_o), 0);
        irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
        chk("R7 stray ack keeps flag", 32'(flags_o[1]), 1);
        write_en(4'b0000);
        clear_flags(3'b111);

        // R8 set wins over same-cycle clear
        tmr_ovf_i = 1'b1; flag_clr_i = 3'b010; tick();
        tmr_ovf_i = 1'b0; flag_clr_i = 3'b000;
        chk("R8 set beats clear", 32'(flags_o[1]), 1);
        clear_flags(3'b010);

        // R4 stack full holds off service
        raise_ext();
        stack_full_i = 1'b1;
        write_en(4'b0011);
        for (int k = 0; k < 4; k++) begin
            chk("R4 no take while full", 32'(irq_take_o), 0);
            tick();
        end
        stack_full_i = 1'b0;
        tick();
        chk("R4 take after room", 32'(irq_take_o), 1);
        chk("R6 ext vector", 32'(irq_vec_o), 32'h04);
        irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
        chk("R7 ext flag cleared", 32'(flags_o[0]), 0);
        chk("R7 gie cleared", 32'(gie_o), 0);

        // R10 no repeat offer before ack, late ack
        pulse_tmr(); pulse_tb();
        write_en(4'b1101);
        tick();
        chk("R6 timer vector", 32'(irq_vec_o), 32'h08);
        chk("R6 take high", 32'(irq_take_o), 1);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R10 no second take", 32'(irq_take_o), 0);
        end
        irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
        chk("R7 late ack clears timer", 32'(flags_o), 3'b100);
        tick();
        chk("R7 no take after gie drop", 32'(irq_take_o), 0);
        write_en(4'b1101);
        tick();
        chk("R6 time-base vector", 32'(irq_vec_o), 32'h0C);
        irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
        write_en(4'b0000);
        clear_flags(3'b111);

        // R5 random priority mixes
        for (int it = 0; it < 30; it++) begin
            logic [2:0] p;
            logic [2:0] e;
            p = 3'($urandom % 8);
            e = 3'($urandom % 8);
            clear_flags(3'b111);
            if (p[0]) raise_ext();
            if (p[1]) pulse_tmr();
            if (p[2]) pulse_tb();
            chk("R3 flags latched", 32'(flags_o), 32'(p));
            write_en({e, 1'b1});
            chk("R4 take latency", 32'(irq_take_o), 0);
            tick();
            if ((p & e) != 3'b000) begin
                chk("R4 take", 32'(irq_take_o), 1);
                chk("R5 winner vector", 32'(irq_vec_o), 32'(exp_vec(p & e)));
                irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
                chk("R7 served flag cleared", 32'(flags_o), 32'(p & ~exp_win(p & e)));
                chk("R7 gie cleared", 32'(gie_o), 0);
            end else begin
                chk("R4 nothing eligible", 32'(irq_take_o), 0);
                write_en(4'b0000);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule